// File: doc/BRIEF.md
# Serial Management Register Target

This block is the target side of a two-wire serial management link, as used to configure a physical-layer transceiver. A host toggles a clock line and a data line in software; the block brings both into its own clock domain, samples the data line on each rising edge of the management clock, and feeds the bit into a 32-bit shift word while a bit counter tracks position in the frame. The block does not decode the frame with a per-field state machine. It inspects the shift word at two fixed bit counts instead: after 16 bits for a read command and after 32 bits for a write command.

A read loads the addressed 16-bit register into the shift word, which then moves out, most significant bit first, on the return data output. A write updates the addressed register through a per-register mask of writable bits. A run of 32 ones, the idle preamble, fills the shift word with ones and sets the counter back to zero. Every frame therefore starts cleanly after a preamble. A direction input says whether the host is driving the data phase or reading it back. The block holds a bank of 32 16-bit registers with fixed reset values. It answers one transceiver address only.

Top module: `mdio_mgmt_target`

## Requirements
- R1: The shift word and bit counter change only on a rising edge of the synchronised management clock. Each edge adds one to the counter and shifts the word left by one place. A steady high or low level, and a falling edge, sample nothing, even while the data line toggles.
- R2: On an edge, the bit shifted in is the data line when the incremented count is below 16 or the direction input is low. When the direction input is high and the incremented count is 16 or more, the bit shifted in is 0.
- R3: The return data output is bit 15 of the shift word while the counter is at 16 or more and the direction input is high. At all other times it is 0, including after reset.
- R4: When an edge leaves the shift word at all ones, the counter returns to 0. A preamble of 32 ones therefore resynchronises the block after any stray bits.
- R5: When the count reaches 16, bits 15:12 are the opcode, bits 11:7 the transceiver address and bits 6:2 the register number. Opcode 6 (binary 0110) loads the addressed register into the low half of the shift word and clears the upper half. After this, 16 further edges present the register MSB first.
- R6: When the count reaches 32, bits 31:28 are the opcode, bits 27:23 the transceiver address, bits 22:18 the register number and bits 15:0 the data. Opcode 5 (binary 0101) writes. Any other opcode leaves the registers unchanged.
- R7: Only transceiver address 1 responds. A read from any other address returns 0. A write to any other address changes nothing.
- R8: A write changes only the bits set in the register's writable mask. The masks are 0xFFFF for registers 1, 2, 3, 5, 6 and 18 to 25. Register 4 has 0xC01F and register 16 has 0x0FFF. All other registers, among them 0 and 17, have 0x0000.
- R9: The reset values are 0x3100 for register 0, 0xF02C for 1, 0x7810 for 2, 0x0501 for 4, 0x4181 for 5, 0x0003 for 16, 0x0600 for 17 and 0x0001 for 18. Every other register resets to 0.
- R10: The 6-bit counter stops at 63 and does not wrap. A long run of edges without a preamble can therefore never bring the count back to the read checkpoint.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| mdcIn | input | 1 | Management clock line from the host, asynchronous |
| mdoIn | input | 1 | Management data line from the host, asynchronous |
| readDirIn | input | 1 | High while the host reads the data phase back |
| mdiOut | output | 1 | Return data line toward the host |

## Verification
The hardest condition to reach from the ports is a counter sitting past the write checkpoint with no preamble in sight. That is the only place where counter saturation differs from wrap-around. To get there, the stimulus follows a complete write frame with exactly 32 zero bits, which carries a wrapping counter back to zero. It then sends a bare read header for a register that was just written with its top bit set. A loaded register would show up as a 1 on the return line, so the line must read 0. A second awkward case is the data line changing while the management clock is held high. Some header bits are sent with the data line toggling during the high phase, and the register value read back must still be exact.

// File: rtl/mdio_tgt_pkg.sv
package mdio_tgt_pkg;

  localparam int WORD_W   = 32;
  localparam int DATA_W   = 16;
  localparam int HDR_BITS = 16;

  localparam logic [3:0] OP_READ  = 4'd6;
  localparam logic [3:0] OP_WRITE = 4'd5;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic shift;        // sampled rising edge of the management clock
    logic inBit;        // bit entering the shift word on that edge
    logic loadRead;     // replace the shift word with register read data
    logic commitWrite;  // write checkpoint reached with a write opcode
    logic mdiEn;        // return line follows shift word bit 15
  } mdioStrobeT;

endpackage

// File: rtl/mdio_tgt_ctrl.sv
module mdio_tgt_ctrl
  import mdio_tgt_pkg::*;
#(
  parameter int CNT_W     = 6,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                mdcRaw,
  input  logic                mdoRaw,
  input  logic                readDirRaw,
  input  logic [WORD_W-1:0]   shiftWord,
  output mdioStrobeT          strobes,
  output logic [CNT_W-1:0]    bitCount
);

  localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_READ  = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] CNT_WRITE = CNT_W'(WORD_W);

  // synchroniser chains: bit 0 = mdc, bit 1 = mdo, bit 2 = direction
  logic [2:0] syncStage [SYNC_DEPTH];
  logic       mdcPrev;

  genvar s;
  generate
    for (s = 0; s < SYNC_DEPTH; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) begin
          syncStage[s] <= '0;
        end else if (s == 0) begin
          syncStage[s] <= {readDirRaw, mdoRaw, mdcRaw};
        end else begin
          syncStage[s] <= syncStage[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  logic mdcS, mdoS, dirS;
  assign mdcS = syncStage[SYNC_DEPTH-1][0];
  assign mdoS = syncStage[SYNC_DEPTH-1][1];
  assign dirS = syncStage[SYNC_DEPTH-1][2];

  always_ff @(posedge clk) begin
    if (!rstN) mdcPrev <= 1'b0;
    else       mdcPrev <= mdcS;
  end

  logic              riseEdge;
  logic [CNT_W-1:0]  cntInc;
  logic              inBit;
  logic [WORD_W-1:0] candidate;
  logic              allOnes;

  always_comb begin
    riseEdge  = mdcS & ~mdcPrev;
    cntInc    = (bitCount == CNT_MAX) ? bitCount : bitCount + 1'b1;
    inBit     = ((cntInc < CNT_READ) || !dirS) ? mdoS : 1'b0;
    candidate = {shiftWord[WORD_W-2:0], inBit};
    allOnes   = &candidate;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCount <= '0;
    end else if (riseEdge) begin
      bitCount <= allOnes ? '0 : cntInc;
    end
  end

  always_comb begin
    strobes.shift       = riseEdge;
    strobes.inBit       = inBit;
    strobes.loadRead    = riseEdge && !allOnes && (cntInc == CNT_READ) &&
                          (candidate[15:12] == OP_READ);
    strobes.commitWrite = riseEdge && !allOnes && (cntInc == CNT_WRITE) &&
                          (candidate[31:28] == OP_WRITE);
    strobes.mdiEn       = (bitCount >= CNT_READ) && dirS;
  end

endmodule

// File: rtl/mdio_tgt_data.sv
module mdio_tgt_data
  import mdio_tgt_pkg::*;
#(
  parameter int PHY_ADDR  = 1,
  parameter int REG_COUNT = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  mdioStrobeT        strobes,
  output logic [WORD_W-1:0] shiftWord,
  output logic              mdiOut
);

  function automatic logic [DATA_W-1:0] regDefault(input int idx);
    case (idx)
      0:       return 16'h3100;
      1:       return 16'hF02C;
      2:       return 16'h7810;
      4:       return 16'h0501;
      5:       return 16'h4181;
      16:      return 16'h0003;
      17:      return 16'h0600;
      18:      return 16'h0001;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] regMask(input int idx);
    if (idx >= 1 && idx <= 3)        return 16'hFFFF;
    else if (idx == 4)               return 16'hC01F;
    else if (idx == 5 || idx == 6)   return 16'hFFFF;
    else if (idx == 16)              return 16'h0FFF;
    else if (idx >= 18 && idx <= 25) return 16'hFFFF;
    else                             return 16'h0000;
  endfunction

  logic [DATA_W-1:0] bank [REG_COUNT];
  logic [WORD_W-1:0] candidate;

  // fields at the read checkpoint
  logic [4:0]        rdPhy, rdReg;
  // fields at the write checkpoint
  logic [4:0]        wrPhy, wrReg;
  logic [DATA_W-1:0] wrData;
  logic [DATA_W-1:0] readVal;
  logic              wrHit;

  always_comb begin
    candidate = {shiftWord[WORD_W-2:0], strobes.inBit};
    rdPhy  = candidate[11:7];
    rdReg  = candidate[6:2];
    wrPhy  = candidate[27:23];
    wrReg  = candidate[22:18];
    wrData = candidate[15:0];
    wrHit  = strobes.commitWrite && (wrPhy == 5'(PHY_ADDR));
  end

  always_comb begin
    readVal = '0;
    for (int i = 0; i < REG_COUNT; i++) begin
      if (rdReg == 5'(i)) readVal = bank[i];
    end
    if (rdPhy != 5'(PHY_ADDR)) readVal = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) bank[i] <= regDefault(i);
    end else if (wrHit) begin
      for (int i = 0; i < REG_COUNT; i++) begin
        if (wrReg == 5'(i)) begin
          bank[i] <= (bank[i] & ~regMask(i)) | (wrData & regMask(i));
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftWord <= '0;
    end else if (strobes.shift) begin
      shiftWord <= strobes.loadRead ? {{(WORD_W-DATA_W){1'b0}}, readVal}
                                    : candidate;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) mdiOut <= 1'b0;
    else       mdiOut <= strobes.mdiEn & shiftWord[DATA_W-1];
  end

endmodule

// File: rtl/mdio_mgmt_target.sv
module mdio_mgmt_target
  import mdio_tgt_pkg::*;
#(
  parameter int PHY_ADDR  = 1,
  parameter int REG_COUNT = 32,
  parameter int CNT_W     = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic mdcIn,
  input  logic mdoIn,
  input  logic readDirIn,
  output logic mdiOut
);

  mdioStrobeT        strobes;
  logic [CNT_W-1:0]  bitCount;
  logic [WORD_W-1:0] shiftWord;

  mdio_tgt_ctrl #(.CNT_W(CNT_W), .SYNC_DEPTH(2)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .mdcRaw     (mdcIn),
    .mdoRaw     (mdoIn),
    .readDirRaw (readDirIn),
    .shiftWord  (shiftWord),
    .strobes    (strobes),
    .bitCount   (bitCount)
  );

  mdio_tgt_data #(.PHY_ADDR(PHY_ADDR), .REG_COUNT(REG_COUNT)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .shiftWord (shiftWord),
    .mdiOut    (mdiOut)
  );

endmodule

// File: rtl/mdio_mgmt_target_chk.sv
module mdio_mgmt_target_chk
  import mdio_tgt_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input mdioStrobeT        st,
  input logic [CNT_W-1:0]  bitCount,
  input logic [WORD_W-1:0] shiftWord,
  input logic              mdiOut
);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !st.shift |=> ($stable(bitCount) && $stable(shiftWord)));

  p_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    (st.shift && bitCount < CNT_W'(31)) |=>
      ((bitCount == $past(bitCount) + 1'b1) || (bitCount == '0)));

  p_zero_in_r2: assert property (@(posedge clk) disable iff (!rstN)
    (st.shift && st.mdiEn && !st.loadRead) |=> !shiftWord[0]);

  p_mdi_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (bitCount < CNT_W'(16)) |=> !mdiOut);

  p_load_at16_r5: assert property (@(posedge clk) disable iff (!rstN)
    st.loadRead |=> (bitCount == CNT_W'(16)));

  p_write_at32_r6: assert property (@(posedge clk) disable iff (!rstN)
    st.commitWrite |=> (bitCount == CNT_W'(32)));

endmodule

bind mdio_mgmt_target mdio_mgmt_target_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .st        (strobes),
  .bitCount  (bitCount),
  .shiftWord (shiftWord),
  .mdiOut    (mdiOut)
);

// File: tb/mdio_mgmt_target_test.sv
module mdio_mgmt_target_test;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mdc = 1'b0;
  logic mdo = 1'b0;
  logic rdDir = 1'b0;
  logic mdi;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_mgmt_target uut (
    .clk       (clk),
    .rstN      (rstN),
    .mdcIn     (mdc),
    .mdoIn     (mdo),
    .readDirIn (rdDir),
    .mdiOut    (mdi)
  );

  // [47] write first, [46:42] write address, [41:37] register,
  // [36:32] read address, [31:16] write data, [15:0] expected read
  localparam logic [47:0] VEC [16] = '{
    {1'b0, 5'd1, 5'd0,  5'd1, 16'h0000, 16'h3100},  // R9
    {1'b0, 5'd1, 5'd1,  5'd1, 16'h0000, 16'hF02C},  // R9
    {1'b0, 5'd1, 5'd2,  5'd1, 16'h0000, 16'h7810},  // R9
    {1'b0, 5'd1, 5'd4,  5'd1, 16'h0000, 16'h0501},  // R9
    {1'b0, 5'd1, 5'd5,  5'd1, 16'h0000, 16'h4181},  // R9
    {1'b0, 5'd1, 5'd16, 5'd1, 16'h0000, 16'h0003},  // R9
    {1'b0, 5'd1, 5'd17, 5'd1, 16'h0000, 16'h0600},  // R9
    {1'b0, 5'd1, 5'd18, 5'd1, 16'h0000, 16'h0001},  // R9
    {1'b0, 5'd1, 5'd0,  5'd2, 16'h0000, 16'h0000},  // R7 other address
    {1'b1, 5'd1, 5'd0,  5'd1, 16'hFFFF, 16'h3100},  // R8 read-only
    {1'b1, 5'd1, 5'd4,  5'd1, 16'hFFFF, 16'hC51F},  // R8 partial mask
    {1'b1, 5'd1, 5'd4,  5'd1, 16'h0000, 16'h0500},  // R8 partial mask
    {1'b1, 5'd1, 5'd16, 5'd1, 16'hA5A5, 16'h05A5},  // R8 low 12 bits
    {1'b1, 5'd1, 5'd1,  5'd1, 16'h1234, 16'h1234},  // R6 full write
    {1'b1, 5'd3, 5'd1,  5'd1, 16'hBEEF, 16'h1234},  // R7 write ignored
    {1'b1, 5'd1, 5'd17, 5'd1, 16'hFFFF, 16'h0600}   // R8 read-only
  };

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check16(input string tag, input logic [15:0] act,
                         input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clockBit(input logic b, input bit noisy);
    mdo = b;
    waitCyc(4);
    mdc = 1'b1;
    waitCyc(2);
    if (noisy) begin
      for (int t = 0; t < 6; t++) begin
        mdo = ~mdo;
        waitCyc(1);
      end
    end else begin
      waitCyc(6);
    end
    mdc = 1'b0;
    waitCyc(4);
  endtask

  task automatic sendBits(input logic [31:0] v, input int n, input bit noisy);
    for (int i = n - 1; i >= 0; i--) clockBit(v[i], noisy);
  endtask

  task automatic preamble();
    rdDir = 1'b0;
    waitCyc(4);
    repeat (32) clockBit(1'b1, 1'b0);
  endtask

  task automatic writeFrame(input logic [3:0] op, input logic [4:0] phy,
                            input logic [4:0] ra, input logic [15:0] d);
    preamble();
    sendBits({op, phy, ra, 2'b10, d}, 32, 1'b0);
  endtask

  task automatic readFrame(input logic [4:0] phy, input logic [4:0] ra,
                           input bit noisy, output logic [15:0] d,
                           output logic tail);
    preamble();
    sendBits({13'b0, 4'd6, phy, ra, 1'b0}, 15, noisy);
    rdDir = 1'b1;
    waitCyc(4);
    clockBit(1'b0, 1'b0);
    d[15] = mdi;
    for (int k = 14; k >= 0; k--) begin
      clockBit(1'b1, 1'b0);   // data line held high during the data phase
      d[k] = mdi;
    end
    clockBit(1'b1, 1'b0);
    tail = mdi;
    rdDir = 1'b0;
    waitCyc(4);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    logic        tail;

    rstN = 1'b0;
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(3);
    check16("R3 reset return line", {15'b0, mdi}, 16'h0000);

    for (int i = 0; i < 16; i++) begin
      if (VEC[i][47]) writeFrame(4'd5, VEC[i][46:42], VEC[i][41:37], VEC[i][31:16]);
      readFrame(VEC[i][36:32], VEC[i][41:37], 1'b0, rd, tail);
      check16($sformatf("R5 R7 R8 R9 vector %0d", i), rd, VEC[i][15:0]);
    end

    // R2: bit shifted at the first data-phase edge reaches bit 15 after edge 32
    readFrame(5'd1, 5'd2, 1'b0, rd, tail);
    check16("R2 zero shifted while reading", {15'b0, tail}, 16'h0000);

    // R1: data line toggles while the management clock is held high
    readFrame(5'd1, 5'd5, 1'b1, rd, tail);
    check16("R1 level-held clock samples once", rd, 16'h4181);

    // R3: direction high but count below 16, bit 15 of the word is 1
    preamble();
    rdDir = 1'b1;
    waitCyc(4);
    clockBit(1'b0, 1'b0);
    check16("R3 quiet before checkpoint", {15'b0, mdi}, 16'h0000);
    rdDir = 1'b0;
    waitCyc(4);

    // R4: stray bits before a preamble
    sendBits(32'h0000_0053, 7, 1'b0);
    readFrame(5'd1, 5'd2, 1'b0, rd, tail);
    check16("R4 resync after stray bits", rd, 16'h7810);

    // R10: write, then 32 zero bits, then a bare read header
    writeFrame(4'd5, 5'd1, 5'd3, 16'h8000);
    repeat (32) clockBit(1'b0, 1'b0);
    sendBits({13'b0, 4'd6, 5'd1, 5'd3, 1'b0}, 15, 1'b0);
    rdDir = 1'b1;
    waitCyc(4);
    clockBit(1'b0, 1'b0);
    check16("R10 counter holds at 63", {15'b0, mdi}, 16'h0000);
    rdDir = 1'b0;
    waitCyc(4);

    readFrame(5'd1, 5'd3, 1'b0, rd, tail);
    check16("R6 write of register 3", rd, 16'h8000);

    // R6: non-write opcode at the write checkpoint
    writeFrame(4'd7, 5'd1, 5'd3, 16'h0000);
    readFrame(5'd1, 5'd3, 1'b0, rd, tail);
    check16("R6 other opcode ignored", rd, 16'h8000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule